// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a DDR2-style SDRAM, as they are driven by a controller, and decodes them on each rising clock edge. It turns the active-low chip select, row strobe, column strobe and write enable into a one-hot command. Next to that command it reports the bank the command targets, the mode-register selection for a mode-register-set cycle, and the meaning of address bit 10. That bit is an all-banks flag on a precharge and an auto-precharge flag on a read or write.

The block also holds the open or closed state of every bank, together with the row that each open bank was activated with. A one-cycle error pulse flags any command that the current bank state does not allow. A rejected command leaves the bank state as it was. The block suits a protocol monitor beside a memory model, or a sequencing guard placed inside a controller. Data, strobes and electrical behaviour are outside its scope.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Pins are sampled on the rising clock edge, and every output is registered, so a result appears one cycle after its command. While `rst_n` is low at a rising edge, `cmd_o` becomes the deselect bit, all banks become closed, all rows become zero and every flag, including `err_o`, becomes 0.
- R2: `cmd_o` always has exactly one bit set, at these positions: bit 0 deselect, bit 1 no-op, bit 2 activate, bit 3 read, bit 4 write, bit 5 precharge, bit 6 refresh, bit 7 mode register set. With `cs_n`=1 the result is deselect whatever the other pins are. With `cs_n`=0 the pins {ras_n,cas_n,we_n} decode as follows: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set.
- R3: `bank_o` equals the sampled {ba[1],ba[0]} (00 is bank 0, 11 is bank 3) for activate, read, write and precharge, and is 0 for every other command.
- R4: `mode_ext_o` equals `ba[0]` on a mode register set (1 selects the extended register), and is 0 for every other command.
- R5: An activate to a closed bank opens that bank and stores `addr[13:0]` in `row_o[b*14 +: 14]`, where b is the bank number.
- R6: A precharge with `addr[10]`=0 closes only the addressed bank. A precharge with `addr[10]`=1 closes all four banks. `all_banks_o` equals `addr[10]` on a precharge and is 0 otherwise. A precharge to a closed bank is legal.
- R7: `auto_pre_o` equals `addr[10]` on a read or write and is 0 otherwise. An accepted read or write with `addr[10]`=1 closes its bank. With `addr[10]`=0 the bank stays open.
- R8: A read or write to a closed bank, or an activate to an open bank, raises `err_o` for one cycle and leaves all bank open flags and rows unchanged.
- R9: A refresh while any bank is open raises `err_o`. A refresh with all banks closed is accepted without error. A refresh never changes the bank state.
- R10: The unused code {cs_n,ras_n,cas_n,we_n}=0110 decodes as no-op and raises `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row, column, auto-precharge bit and mode opcode |
| cmd_o | output | 8 | One-hot decoded command |
| bank_o | output | 2 | Bank the command targets |
| mode_ext_o | output | 1 | Extended mode register selected |
| all_banks_o | output | 1 | Precharge applies to all banks |
| auto_pre_o | output | 1 | Read or write carries auto-precharge |
| bank_open_o | output | 4 | Per-bank open flag |
| row_o | output | 56 | Latched row of each bank, 14 bits per bank |
| err_o | output | 1 | One-cycle protocol error pulse |

## Verification
Every result of this block is due exactly one rising edge after the command that causes it. That includes the decoded command, its qualifiers, the error pulse and the updated bank flags and rows. The bench therefore drives each command on a falling edge and reads all outputs 1 ns after the next rising edge, before it drives anything else. A bench model of the banks is updated in the same step, so each observation is compared with the state that command must leave. Reset is checked the same way, one edge after reset is released, with deselect on the pins.

// File: rtl/sdram_cmd_pkg.sv
// Shared definitions for the SDRAM command tracker.
// Assumes one-hot command vectors indexed by cmd_idx_e.
package sdram_cmd_pkg;
    localparam int CMD_N = 8;

    typedef enum logic [2:0] {
        C_DESEL = 3'd0,
        C_NOP   = 3'd1,
        C_ACT   = 3'd2,
        C_RD    = 3'd3,
        C_WR    = 3'd4,
        C_PRE   = 3'd5,
        C_REF   = 3'd6,
        C_MRS   = 3'd7
    } cmd_idx_e;

    typedef logic [CMD_N-1:0] cmd_vec_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational pin decoder: maps the active-low control pins to a
// one-hot command. Assumes pins are already stable at the sampling edge.
// The spare code 0110 is reported as no-op with a reserved flag.
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output cmd_vec_t cmd,
    output logic     reserved
);
    // Pin pattern to one-hot command
    always_comb begin
        cmd      = '0;
        reserved = 1'b0;
        if (cs_n) begin
            cmd[C_DESEL] = 1'b1;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd[C_NOP] = 1'b1;
                3'b011: cmd[C_ACT] = 1'b1;
                3'b101: cmd[C_RD]  = 1'b1;
                3'b100: cmd[C_WR]  = 1'b1;
                3'b010: cmd[C_PRE] = 1'b1;
                3'b001: cmd[C_REF] = 1'b1;
                3'b000: cmd[C_MRS] = 1'b1;
                default: begin
                    cmd[C_NOP] = 1'b1;
                    reserved   = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdram_seq_check.sv
// Legality check of a decoded command against the current bank state.
// Assumes bank_open reflects the state before this command takes effect.
module sdram_seq_check
    import sdram_cmd_pkg::*;
#(
    parameter int BA_W      = 2,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  cmd_vec_t             cmd,
    input  logic                 reserved,
    input  logic [BA_W-1:0]      ba,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 err
);
    logic tgt_open;
    logic rw;

    // Flag access to a closed bank, reopen of an open bank, busy refresh
    always_comb begin
        tgt_open = bank_open[ba];
        rw       = cmd[C_RD] | cmd[C_WR];
        err      = reserved
                 | (rw & ~tgt_open)
                 | (cmd[C_ACT] & tgt_open)
                 | (cmd[C_REF] & (|bank_open));
    end
endmodule

// File: rtl/sdram_bank_slot.sv
// State of one bank: open flag plus the row latched at activate.
// Assumes open_en and close_en are never both set for an accepted command;
// open_en wins if they are.
module sdram_bank_slot #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    // Open/close sequencing and row capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (open_en) begin
            open_o <= 1'b1;
            row_o  <= row_in;
        end else if (close_en) begin
            open_o <= 1'b0;
        end
    end

    a_r5_open_latches: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |=> (open_o && row_o == $past(row_in)));

    a_r6_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && !open_en) |=> !open_o);
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top: registers the decoded command and its qualifiers, runs the
// legality check, and keeps one bank slot per bank. All outputs change
// one clock after the sampled command. Synchronous active-low reset.
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [CMD_N-1:0]           cmd_o,
    output logic [BA_W-1:0]            bank_o,
    output logic                       mode_ext_o,
    output logic                       all_banks_o,
    output logic                       auto_pre_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] row_o,
    output logic                       err_o
);
    cmd_vec_t             cmd_d;
    logic                 reserved_d;
    logic                 err_d;
    logic                 rw_d;
    logic                 ap_bit;
    logic                 tgt_d;
    logic [NUM_BANKS-1:0] open_s;

    cmd_vec_t             cmd_q;
    logic [BA_W-1:0]      bank_q;
    logic                 ext_q;
    logic                 all_q;
    logic                 ap_q;
    logic                 err_q;

    sdram_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cmd      (cmd_d),
        .reserved (reserved_d)
    );

    sdram_seq_check #(.BA_W(BA_W)) u_chk (
        .cmd       (cmd_d),
        .reserved  (reserved_d),
        .ba        (ba),
        .bank_open (open_s),
        .err       (err_d)
    );

    // Helper terms shared by the bank enables and the output registers
    always_comb begin
        rw_d   = cmd_d[C_RD] | cmd_d[C_WR];
        ap_bit = addr[AP_BIT];
        tgt_d  = cmd_d[C_ACT] | rw_d | cmd_d[C_PRE];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic open_en;
        logic close_en;

        // Per-bank open and close enables from the accepted command
        always_comb begin
            hit      = (ba == BA_W'(b));
            open_en  = cmd_d[C_ACT] & hit & ~err_d;
            close_en = (cmd_d[C_PRE] & (ap_bit | hit))
                     | (rw_d & ap_bit & hit & ~err_d);
        end

        sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_en  (open_en),
            .close_en (close_en),
            .row_in   (addr),
            .open_o   (open_s[b]),
            .row_o    (row_o[b*ROW_W +: ROW_W])
        );
    end

    // Output register stage for the command and its qualifiers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= cmd_vec_t'(1) << C_DESEL;
            bank_q <= '0;
            ext_q  <= 1'b0;
            all_q  <= 1'b0;
            ap_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_d;
            bank_q <= tgt_d ? ba : '0;
            ext_q  <= cmd_d[C_MRS] & ba[0];
            all_q  <= cmd_d[C_PRE] & ap_bit;
            ap_q   <= rw_d & ap_bit;
            err_q  <= err_d;
        end
    end

    assign cmd_o       = cmd_q;
    assign bank_o      = bank_q;
    assign mode_ext_o  = ext_q;
    assign all_banks_o = all_q;
    assign auto_pre_o  = ap_q;
    assign bank_open_o = open_s;
    assign err_o       = err_q;

    a_r2_onehot_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_o) == 1);

    a_r4_ext_only_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ext_o |-> cmd_o[C_MRS]);

    a_r6_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        all_banks_o |-> (bank_open_o == '0));

    a_r7_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o[C_RD] || cmd_o[C_WR]) && auto_pre_o && !err_o)
            |-> !bank_open_o[bank_o]);

    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (bank_open_o == $past(bank_open_o)));

    a_r9_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_REF] && !err_o) |-> (bank_open_o == '0));
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
    localparam int B_DESEL = 0, B_NOP = 1, B_ACT = 2, B_RD = 3;
    localparam int B_WR = 4, B_PRE = 5, B_REF = 6, B_MRS = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [7:0]  cmd_o;
    logic [1:0]  bank_o;
    logic        mode_ext_o, all_banks_o, auto_pre_o, err_o;
    logic [3:0]  bank_open_o;
    logic [55:0] row_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        m_open [4];
    logic [13:0] m_row  [4];

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
        .mode_ext_o(mode_ext_o), .all_banks_o(all_banks_o),
        .auto_pre_o(auto_pre_o), .bank_open_o(bank_open_o), .row_o(row_o),
        .err_o(err_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Expected one-hot position from the R2 encoding
    function automatic int exp_bit(input logic [3:0] code);
        if (code[3]) return B_DESEL;
        case (code[2:0])
            3'b111:  return B_NOP;
            3'b011:  return B_ACT;
            3'b101:  return B_RD;
            3'b100:  return B_WR;
            3'b010:  return B_PRE;
            3'b001:  return B_REF;
            3'b000:  return B_MRS;
            default: return B_NOP;
        endcase
    endfunction

    function automatic logic [55:0] model_rows();
        logic [55:0] r;
        for (int i = 0; i < 4; i++) r[i*14 +: 14] = m_row[i];
        return r;
    endfunction

    function automatic logic [3:0] model_open();
        logic [3:0] o;
        for (int i = 0; i < 4; i++) o[i] = m_open[i];
        return o;
    endfunction

    // Drive one command, predict from the requirements, check after the edge
    task automatic step(input logic [3:0] code, input logic [1:0] b,
                        input logic [13:0] a);
        int  k;
        logic any, rsv, e_err, rw, e_ext, e_all, e_ap;
        logic [1:0] e_bank;
        string tcmd, tst;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = code;
        ba   = b;
        addr = a;
        k   = exp_bit(code);
        rsv = (code == 4'b0110);
        any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
        rw  = (k == B_RD) || (k == B_WR);
        e_err = rsv || (rw && !m_open[b]) || (k == B_ACT && m_open[b])
                    || (k == B_REF && any);
        e_bank = (k == B_ACT || rw || k == B_PRE) ? b : 2'b00;
        e_ext  = (k == B_MRS) && b[0];
        e_all  = (k == B_PRE) && a[10];
        e_ap   = rw && a[10];
        tcmd = rsv ? "R10" : "R2";
        tst  = rsv ? "R10" : (k == B_REF) ? "R9" : (k == B_PRE) ? "R6"
             : rw ? (e_err ? "R8" : "R7") : (k == B_ACT) ? (e_err ? "R8" : "R5")
             : "R2";
        if (!e_err) begin
            if (k == B_ACT) begin
                m_open[b] = 1'b1;
                m_row[b]  = a;
            end else if (k == B_PRE) begin
                if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
                else m_open[b] = 1'b0;
            end else if (rw && a[10]) begin
                m_open[b] = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        chk(tcmd, "cmd_o", 64'(cmd_o), 64'(8'(1) << k));
        chk("R3", "bank_o", 64'(bank_o), 64'(e_bank));
        chk("R4", "mode_ext_o", 64'(mode_ext_o), 64'(e_ext));
        chk("R6", "all_banks_o", 64'(all_banks_o), 64'(e_all));
        chk("R7", "auto_pre_o", 64'(auto_pre_o), 64'(e_ap));
        chk(tst, "bank_open_o", 64'(bank_open_o), 64'(model_open()));
        chk(tst, "row_o", 64'(row_o), 64'(model_rows()));
        chk(tst, "err_o", 64'(err_o), 64'(e_err));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5150);
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 1'b0;
            m_row[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state, one edge after release with deselect on the pins
        chk("R1", "cmd_o reset", 64'(cmd_o), 64'(8'b0000_0001));
        chk("R1", "bank_open reset", 64'(bank_open_o), 64'd0);
        chk("R1", "row reset", 64'(row_o), 64'd0);
        chk("R1", "err reset", 64'(err_o), 64'd0);
        chk("R1", "flags reset",
            64'({mode_ext_o, all_banks_o, auto_pre_o, bank_o}), 64'd0);

        // Directed corner cases
        step(4'b1011, 2'd1, 14'h0123);   // R2 deselect masks an activate
        step(4'b0011, 2'd2, 14'h2ABC);   // R5 open bank 2
        step(4'b0011, 2'd2, 14'h1111);   // R8 activate of open bank
        step(4'b0101, 2'd1, 14'h0000);   // R8 read of closed bank
        step(4'b0001, 2'd0, 14'h0000);   // R9 refresh while open
        step(4'b0100, 2'd2, 14'h0012);   // R7 write, bank stays open
        step(4'b0101, 2'd2, 14'h0412);   // R7 read with auto-precharge
        step(4'b0011, 2'd0, 14'h3FFF);   // R5
        step(4'b0011, 2'd1, 14'h0001);   // R5
        step(4'b0011, 2'd3, 14'h2000);   // R5
        step(4'b0010, 2'd1, 14'h0000);   // R6 single-bank precharge
        step(4'b0010, 2'd0, 14'h0400);   // R6 all-banks precharge
        step(4'b0001, 2'd3, 14'h0000);   // R9 refresh with all closed
        step(4'b0000, 2'd1, 14'h0042);   // R4 extended register
        step(4'b0000, 2'd0, 14'h0042);   // R4 base register
        step(4'b0110, 2'd2, 14'h0000);   // R10 spare code
        step(4'b0111, 2'd3, 14'h0400);   // R2 no-op

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned pick;
            logic [3:0]  code;
            logic [13:0] a;
            pick = $urandom % 16;
            case (pick)
                0, 1, 2, 3: code = 4'b0011;
                4, 5:       code = 4'b0101;
                6, 7:       code = 4'b0100;
                8, 9:       code = 4'b0010;
                10:         code = 4'b0001;
                11:         code = 4'b0000;
                12:         code = 4'b0111;
                13:         code = 4'b0110;
                default:    code = {1'b1, 3'($urandom)};
            endcase
            a = 14'($urandom);
            if (code == 4'b0010 && ($urandom % 4) != 0) a[10] = 1'b0;
            step(code, 2'($urandom), a);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5ns * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: got running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule